// File: doc/BRIEF.md
# UART Interrupt Identification and Priority

This block decides which interrupt a 16550-style serial port presents to the host. It takes six inputs: the interrupt enable bits, the receiver error flags, the receive FIFO fill count and trigger level, the FIFO-enable mode bit, a character-timeout indication and the modem-status change bits. It also keeps one piece of state of its own, the transmit-empty pending flag. From these it forms the identification register value and the interrupt line, both combinationally.

The pending flag is set when the transmitter becomes empty, or when the host enables the transmit-empty interrupt while the transmitter is already empty. A write to the holding register clears it. A read of the identification register also clears it, but only when that read returned the transmit-empty code. A read that returned a higher-priority source leaves the flag set, so no transmit interrupt is lost. A receive interrupt that is held back because the FIFO is below its trigger level does not block the lower sources; evaluation falls through to them.

Top module: `uart_irq_ident`

## Requirements
- R1: With the line-status enable (enable bit 2) set and any receiver error bit set, the code in bits 3:0 of the identification value is 0x6, whatever other sources are active.
- R2: If R1 does not apply, a character timeout with the receive enable (enable bit 0) set gives code 0xC.
- R3: If R1 and R2 do not apply, code 0x4 is reported when the receive enable is set, data ready is set and either FIFO mode is off or the receive count is greater than or equal to the trigger level.
- R4: A receive source that is held back only because the count is below the trigger level does not mask lower sources: the transmit-empty or modem-status code is reported instead.
- R5: After the receive sources, code 0x2 is reported when the transmit enable (enable bit 1) is set and the pending flag is set. Otherwise code 0x0 is reported when the modem enable (enable bit 3) is set and any modem-change bit is set. Otherwise the code is 0x1 (no interrupt).
- R6: Bits 7:6 of the identification value are 11 in FIFO mode and 00 otherwise, and bits 5:4 are 0. The interrupt line is high exactly when the code is not 0x1.
- R7: The pending flag becomes set one clock after a rising edge of the transmitter-empty input. It also becomes set one clock after the transmit enable rises while the transmitter-empty input is high.
- R8: A read strobe clears the pending flag at the next clock only when the code presented during that read was 0x2. A read that presented any other code leaves the flag unchanged.
- R9: A write strobe to the holding register clears the pending flag at the next clock. A set event from R7 in the same cycle takes precedence, and the flag ends up set.
- R10: Synchronous reset clears the pending flag. With all inputs low, the identification value after reset is 0x01 and the interrupt line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_i | input | 4 | Enables: bit0 receive, bit1 transmit empty, bit2 line status, bit3 modem |
| fifo_en_i | input | 1 | FIFO mode enabled |
| data_ready_i | input | 1 | Receive data ready |
| line_err_i | input | 4 | Receiver error flags (overrun, parity, framing, break) |
| rx_count_i | input | 5 | Receive FIFO fill count |
| rx_trig_i | input | 5 | Receive trigger level |
| char_timeout_i | input | 1 | Character timeout condition |
| tx_empty_i | input | 1 | Transmit holding register / FIFO empty |
| thr_write_i | input | 1 | Host write strobe to holding register |
| iir_read_i | input | 1 | Host read strobe of identification register |
| modem_delta_i | input | 4 | Modem-status change bits |
| iir_o | output | 8 | Identification register value |
| irq_o | output | 1 | Interrupt line |

## Verification
The assertions assume that every input is a clean synchronous level or a one-cycle strobe. They also assume that the read and write strobes match the code that was visible in the same cycle, and that the transmitter-empty input changes only through real transitions after reset. The stimulus holds the strobes and the transmitter-empty input steady during the static priority sweeps. It changes them only in the directed sequences for the pending flag, and each change is a single strobe between two sampled points.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int IER_W   = 4;
    localparam int ERR_W   = 4;
    localparam int DELTA_W = 4;

    typedef enum logic [3:0] {
        IID_MODEM = 4'h0,
        IID_NONE  = 4'h1,
        IID_TXE   = 4'h2,
        IID_RXD   = 4'h4,
        IID_LINE  = 4'h6,
        IID_TMO   = 4'hC
    } iid_e;

    typedef struct packed {
        logic en_modem;
        logic en_line;
        logic en_tx;
        logic en_rx;
    } ier_t;

    typedef struct packed {
        logic line;
        logic tmo;
        logic rxd;
        logic txe;
        logic modem;
    } src_t;

    function automatic iid_e pick_source(src_t s);
        iid_e c;
        if (s.line)       c = IID_LINE;
        else if (s.tmo)   c = IID_TMO;
        else if (s.rxd)   c = IID_RXD;
        else if (s.txe)   c = IID_TXE;
        else if (s.modem) c = IID_MODEM;
        else              c = IID_NONE;
        return c;
    endfunction

    function automatic logic [7:0] pack_iir(iid_e c, logic fifo_mode);
        return {{2{fifo_mode}}, 2'b00, c};
    endfunction

endpackage

// File: rtl/uart_irq_rx_gate.sv
module uart_irq_rx_gate #(
    parameter int CNT_W = 5
) (
    input  logic             data_ready_i,
    input  logic             fifo_en_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] trig_i,
    output logic             rx_ok_o
);
    logic level_met;

    always_comb begin
        level_met = (count_i >= trig_i);
        rx_ok_o   = data_ready_i && (!fifo_en_i || level_met);
    end

endmodule

// File: rtl/uart_irq_thre_flag.sv
module uart_irq_thre_flag (
    input  logic clk,
    input  logic rst,
    input  logic tx_empty_i,
    input  logic tx_en_i,
    input  logic wr_i,
    input  logic rd_i,
    input  logic tx_reported_i,
    output logic pend_o
);
    logic pend_q, empty_prev_q, en_prev_q;
    logic set_evt, clr_evt;

    always_comb begin
        set_evt = (tx_empty_i && !empty_prev_q) ||
                  (tx_en_i && !en_prev_q && tx_empty_i);
        clr_evt = wr_i || (rd_i && tx_reported_i);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q       <= 1'b0;
            empty_prev_q <= tx_empty_i;
            en_prev_q    <= tx_en_i;
        end else begin
            empty_prev_q <= tx_empty_i;
            en_prev_q    <= tx_en_i;
            if (set_evt)      pend_q <= 1'b1;
            else if (clr_evt) pend_q <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    AST_READ_KEEPS_FLAG: assert property (@(posedge clk) disable iff (rst)
        pend_q && rd_i && !tx_reported_i && !wr_i |=> pend_q); // R8
    AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        wr_i && !tx_empty_i |=> !pend_q); // R9
    AST_EMPTY_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_empty_i) |=> pend_q); // R7

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  src_t src_i,
    output iid_e code_o
);
    always_comb code_o = pick_source(src_i);

    AST_LINE_FIRST: assert property (@(posedge clk) disable iff (rst)
        src_i.line |-> code_o == IID_LINE); // R1
    AST_TMO_OVER_RXD: assert property (@(posedge clk) disable iff (rst)
        !src_i.line && src_i.tmo |-> code_o == IID_TMO); // R2
    AST_MODEM_LAST: assert property (@(posedge clk) disable iff (rst)
        code_o == IID_MODEM |-> !(src_i.line || src_i.tmo || src_i.rxd || src_i.txe)); // R5

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [IER_W-1:0]   ier_i,
    input  logic               fifo_en_i,
    input  logic               data_ready_i,
    input  logic [ERR_W-1:0]   line_err_i,
    input  logic [CNT_W-1:0]   rx_count_i,
    input  logic [CNT_W-1:0]   rx_trig_i,
    input  logic               char_timeout_i,
    input  logic               tx_empty_i,
    input  logic               thr_write_i,
    input  logic               iir_read_i,
    input  logic [DELTA_W-1:0] modem_delta_i,
    output logic [7:0]         iir_o,
    output logic               irq_o
);
    ier_t ier;
    src_t src;
    iid_e code;
    logic rx_ok, pend;

    assign ier = ier_t'(ier_i);

    uart_irq_rx_gate #(.CNT_W(CNT_W)) u_rx_gate (
        .data_ready_i (data_ready_i),
        .fifo_en_i    (fifo_en_i),
        .count_i      (rx_count_i),
        .trig_i       (rx_trig_i),
        .rx_ok_o      (rx_ok)
    );

    uart_irq_thre_flag u_thre (
        .clk           (clk),
        .rst           (rst),
        .tx_empty_i    (tx_empty_i),
        .tx_en_i       (ier.en_tx),
        .wr_i          (thr_write_i),
        .rd_i          (iir_read_i),
        .tx_reported_i (code == IID_TXE),
        .pend_o        (pend)
    );

    always_comb begin
        src.line  = ier.en_line  && (|line_err_i);
        src.tmo   = ier.en_rx    && char_timeout_i;
        src.rxd   = ier.en_rx    && rx_ok;
        src.txe   = ier.en_tx    && pend;
        src.modem = ier.en_modem && (|modem_delta_i);
    end

    uart_irq_prio u_prio (
        .clk    (clk),
        .rst    (rst),
        .src_i  (src),
        .code_o (code)
    );

    always_comb begin
        iir_o = pack_iir(code, fifo_en_i);
        irq_o = (code != IID_NONE);
    end

    AST_FIFO_BITS: assert property (@(posedge clk) disable iff (rst)
        iir_o[7:4] == {fifo_en_i, fifo_en_i, 2'b00}); // R6
    AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
        irq_o != iir_o[0]); // R6
    AST_HELD_RX_FALLS: assert property (@(posedge clk) disable iff (rst)
        ier_i[0] && data_ready_i && fifo_en_i && (rx_count_i < rx_trig_i) &&
        !char_timeout_i && !(ier_i[2] && |line_err_i) && ier_i[1] && pend
        |-> iir_o[3:0] == 4'h2); // R4

endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
    localparam int CW = 5;

    logic clk = 1'b0;
    logic rst;
    logic [3:0] ier;
    logic fifo_en, dr, tmo, tx_empty, wr, rd;
    logic [3:0] lerr, delta;
    logic [CW-1:0] cnt, trig;
    logic [7:0] iir;
    logic irq;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_irq_ident #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .ier_i(ier), .fifo_en_i(fifo_en),
        .data_ready_i(dr), .line_err_i(lerr), .rx_count_i(cnt),
        .rx_trig_i(trig), .char_timeout_i(tmo), .tx_empty_i(tx_empty),
        .thr_write_i(wr), .iir_read_i(rd), .modem_delta_i(delta),
        .iir_o(iir), .irq_o(irq)
    );

    function automatic logic [7:0] model(logic f);
        logic [3:0] c;
        if (ier[2] && lerr != 0)                          c = 4'h6;
        else if (ier[0] && tmo)                           c = 4'hC;
        else if (ier[0] && dr && (!fifo_en || cnt >= trig)) c = 4'h4;
        else if (ier[1] && f)                             c = 4'h2;
        else if (ier[3] && delta != 0)                    c = 4'h0;
        else                                              c = 4'h1;
        return {fifo_en, fifo_en, 2'b00, c};
    endfunction

    function automatic string tag_of(logic [3:0] c, logic held);
        if (held && (c == 4'h2 || c == 4'h0 || c == 4'h1)) return "R4";
        case (c)
            4'h6: return "R1";
            4'hC: return "R2";
            4'h4: return "R3";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] exp_iir);
        checks++;
        if (iir !== exp_iir || irq !== (exp_iir[3:0] != 4'h1)) begin
            errors++;
            $display("FAIL %s: iir=%02h irq=%0b expected iir=%02h irq=%0b",
                     tag, iir, irq, exp_iir, exp_iir[3:0] != 4'h1);
        end
    endtask

    task automatic sweep(logic f);
        for (int e = 0; e < 16; e++)
        for (int le = 0; le < 2; le++)
        for (int t = 0; t < 2; t++)
        for (int d = 0; d < 2; d++)
        for (int fe = 0; fe < 2; fe++)
        for (int c = 0; c < 4; c++)
        for (int tg = 1; tg < 4; tg++)
        for (int m = 0; m < 2; m++) begin
            logic [7:0] ex;
            logic held;
            @(negedge clk);
            ier = 4'(e); tmo = t[0]; dr = d[0]; fifo_en = fe[0];
            cnt = CW'(c); trig = CW'(tg);
            lerr  = le[0] ? 4'(1 << c)  : 4'h0;
            delta = m[0]  ? 4'(1 << tg) : 4'h0;
            #1;
            ex = model(f);
            held = ier[0] && dr && fifo_en && (cnt < trig) && !tmo &&
                   !(ier[2] && lerr != 0);
            check(tag_of(ex[3:0], held), ex);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ier = 0; fifo_en = 0; dr = 0; tmo = 0; tx_empty = 0;
        wr = 0; rd = 0; lerr = 0; delta = 0; cnt = 0; trig = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        check("R10 reset", 8'h01);

        sweep(1'b0);

        // R7: empty rise sets flag one clock later
        @(negedge clk);
        ier = 4'b0010; fifo_en = 0; dr = 0; tmo = 0; lerr = 0; delta = 0;
        tx_empty = 1'b1; #1;
        check("R7 before edge", 8'h01);
        @(negedge clk); #1;
        check("R7 empty rise", 8'h02);
        // R9: write clears
        @(negedge clk); wr = 1'b1;
        @(negedge clk); wr = 1'b0; #1;
        check("R9 write clears", 8'h01);
        // R7: enable rise while empty
        @(negedge clk); ier = 4'b0000;
        @(negedge clk); ier = 4'b0010; #1;
        check("R7 enable edge cycle", 8'h01);
        @(negedge clk); #1;
        check("R7 enable rise", 8'h02);
        // R8: read reporting receive data keeps flag
        @(negedge clk); ier = 4'b0011; dr = 1'b1; #1;
        check("R8 rx shown", 8'h04);
        rd = 1'b1;
        @(negedge clk); rd = 1'b0; dr = 1'b0; #1;
        check("R8 flag kept", 8'h02);
        rd = 1'b1;
        @(negedge clk); rd = 1'b0; #1;
        check("R8 flag cleared", 8'h01);
        // R9: set event beats write in same cycle
        @(negedge clk); tx_empty = 1'b0;
        @(negedge clk); tx_empty = 1'b1; wr = 1'b1;
        @(negedge clk); wr = 1'b0; #1;
        check("R9 set wins", 8'h02);

        sweep(1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule